// File: doc/BRIEF.md
# Global-history correlating branch predictor

This block predicts the direction of conditional branches. A global shift register records whether each recently resolved branch was taken. On a lookup, the low PC bits and that recorded history together choose one saturating counter. The counter's top bit is the prediction. In effect, the recent outcome pattern picks one of several counter tables, and the PC picks the entry within that table.

A lookup is combinational. It returns the prediction and also the history value it used. The caller keeps that history with the branch. When the branch resolves, the caller sends the PC, the actual outcome and the saved history on the update port. The update trains exactly the counter the lookup read, even if the global register has moved on since then. On the same clock edge, the update shifts the actual outcome into the global register.

Setting the history length to zero turns the block into a plain PC-indexed table of counters.

Top module: `gcorr_predictor`

## Requirements
- R1: After reset, every counter holds the weakly-not-taken value 2^(n-1)-1, so every lookup predicts not taken. The global history reads all zeros.
- R2: Each accepted update shifts the global history left by one place, with the new outcome (1 = taken, 0 = not taken) entering at bit 0. `lk_hist` shows the register as it is now.
- R3: The counter chosen for a lookup or an update sits at index {history, pc[k-1:0]}, with the history in the upper bits. An update uses `upd_hist`, not the current global register.
- R4: An update changes only the one selected counter. Counters for the same PC under other history values, and counters for other PCs, keep their values.
- R5: A taken update adds one to the counter, stopping at 2^n-1.
- R6: A not-taken update subtracts one from the counter, stopping at 0.
- R7: The prediction is the most significant bit of the selected counter.
- R8: With 2-bit counters, a strongly taken entry still predicts taken after one not-taken update. It flips to not taken after the second one.
- R9: PC bits at and above bit k do not affect which counter is chosen.
- R10: With m=0, the history input and output are ignored and tied to zero, and counters are chosen by pc[k-1:0] alone.
- R11: A lookup reflects an update only from the clock edge on which that update is sampled. While `upd_valid` is low, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | max(HIST_W,1) | Global history used for this lookup |
| upd_valid | input | 1 | Update strobe, one branch per cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | max(HIST_W,1) | History returned by the lookup of this branch |

## Verification
The assertions assume that `upd_pc`, `upd_taken` and `upd_hist` hold known values whenever `upd_valid` is high. They also assume that at most one branch resolves per cycle. The stimulus drives every update input on the falling edge, and it returns `upd_valid` to zero a moment after the sampling edge, so each pulse is seen exactly once. The value given for `upd_hist` is usually the history the bench last read. Sometimes it is a random legal history instead, which exercises training of a counter other than the one the current register would pick.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

  // One saturating step up or down for a counter bounded by [0, maxv].
  function automatic int unsigned gcp_sat_step(input int unsigned cur,
                                               input int unsigned maxv,
                                               input logic        up);
    int unsigned res;
    if (up) res = (cur >= maxv) ? maxv : cur + 1;
    else    res = (cur == 0)    ? 0    : cur - 1;
    return res;
  endfunction

  // Weakly-not-taken reset value for a counter of width w.
  function automatic int unsigned gcp_weak_nt(input int unsigned w);
    return (32'd1 << (w - 1)) - 1;
  endfunction

endpackage

// File: rtl/gcp_ghist.sv
module gcp_ghist #(
  parameter int HIST_W = 2,
  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HW_EFF-1:0] hist_o
);

  generate
    if (HIST_W == 0) begin : g_nohist
      assign hist_o = '0;
    end else begin : g_hist
      logic [HW_EFF-1:0] hist_q, hist_d;

      always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
          if (HIST_W == 1) hist_d = outcome;
          else             hist_d = {hist_q[HW_EFF-2:0], outcome};
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
      end

      assign hist_o = hist_q;

      assert_hist_newbit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(outcome)));

      assert_hist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

      if (HIST_W >= 2) begin : g_shift_chk
        assert_hist_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
          shift_en |=> (hist_q[1] == $past(hist_q[0])));
      end
    end
  endgenerate

endmodule

// File: rtl/gcp_index.sv
module gcp_index #(
  parameter int HIST_W = 2,
  parameter int IDX_W  = 10,
  parameter int PC_W   = 32,
  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1,
  localparam int TBL_W  = HIST_W + IDX_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HW_EFF-1:0] hist,
  output logic [TBL_W-1:0]  idx
);

  // History bits pick the table, low PC bits pick the entry (R3, R9).
  generate
    if (HIST_W == 0) begin : g_pc_only
      assign idx = pc[IDX_W-1:0];
    end else begin : g_concat
      assign idx = {hist, pc[IDX_W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/gcp_ctr_table.sv
module gcp_ctr_table
  import gcp_pkg::*;
#(
  parameter int TBL_W = 12,
  parameter int CTR_W = 2,
  localparam int DEPTH = 1 << TBL_W,
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}},
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(gcp_weak_nt(CTR_W))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TBL_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [TBL_W-1:0] wr_idx,
  input  logic             wr_up
);

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] wr_cur, wr_nxt;

  // next-state for the one addressed counter
  always_comb begin
    wr_cur = ctr_q[wr_idx];
    wr_nxt = CTR_W'(gcp_sat_step(int'(wr_cur), int'(CTR_MAX), wr_up));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_nxt;
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

  // checker registers: remember the previous write to compare against the array
  logic             chk_v_q, chk_up_q;
  logic [TBL_W-1:0] chk_idx_q;
  logic [CTR_W-1:0] chk_old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v_q   <= 1'b0;
      chk_up_q  <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= '0;
    end else begin
      chk_v_q   <= wr_en;
      chk_up_q  <= wr_up;
      chk_idx_q <= wr_idx;
      chk_old_q <= wr_cur;
    end
  end

  assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v_q && chk_up_q && chk_old_q == CTR_MAX) |-> (ctr_q[chk_idx_q] == CTR_MAX));

  assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v_q && chk_up_q && chk_old_q != CTR_MAX) |-> (ctr_q[chk_idx_q] == chk_old_q + 1'b1));

  assert_sat_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v_q && !chk_up_q && chk_old_q == '0) |-> (ctr_q[chk_idx_q] == '0));

  assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v_q && !chk_up_q && chk_old_q != '0) |-> (ctr_q[chk_idx_q] == chk_old_q - 1'b1));

endmodule

// File: rtl/gcorr_predictor.sv
module gcorr_predictor #(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int IDX_W  = 10,
  parameter int PC_W   = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [PC_W-1:0]                      lk_pc,
  output logic                                 lk_taken,
  output logic [((HIST_W > 0) ? HIST_W : 1)-1:0] lk_hist,
  input  logic                                 upd_valid,
  input  logic [PC_W-1:0]                      upd_pc,
  input  logic                                 upd_taken,
  input  logic [((HIST_W > 0) ? HIST_W : 1)-1:0] upd_hist
);

  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1;
  localparam int TBL_W  = HIST_W + IDX_W;

  // reset: asserted asynchronously, released on a clock edge through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [HW_EFF-1:0] ghist;
  logic [TBL_W-1:0]  lk_idx, upd_idx;
  logic [CTR_W-1:0]  lk_ctr;

  gcp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (upd_valid),
    .outcome  (upd_taken),
    .hist_o   (ghist)
  );

  gcp_index #(.HIST_W(HIST_W), .IDX_W(IDX_W), .PC_W(PC_W)) u_lk_index (
    .pc   (lk_pc),
    .hist (ghist),
    .idx  (lk_idx)
  );

  gcp_index #(.HIST_W(HIST_W), .IDX_W(IDX_W), .PC_W(PC_W)) u_upd_index (
    .pc   (upd_pc),
    .hist (upd_hist),
    .idx  (upd_idx)
  );

  gcp_ctr_table #(.TBL_W(TBL_W), .CTR_W(CTR_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_idx (lk_idx),
    .rd_ctr (lk_ctr),
    .wr_en  (upd_valid),
    .wr_idx (upd_idx),
    .wr_up  (upd_taken)
  );

  assign lk_taken = lk_ctr[CTR_W-1];   // R7
  assign lk_hist  = ghist;

  // R11: with no update and a steady PC, the prediction cannot move
  assert_pred_hold_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!upd_valid && $stable(lk_pc) && $stable(ghist)) |=> $stable(lk_taken) || !$stable(lk_pc));

endmodule

// File: tb/gcorr_predictor_bench.sv
`timescale 1ns/1ps
module gcorr_predictor_bench;
  localparam int M = 2, N = 2, K = 10, PCW = 32;
  localparam int CMAX = (1 << N) - 1;
  localparam int CINIT = (1 << (N - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [PCW-1:0] lk_pc = '0, upd_pc = '0;
  logic           upd_valid = 1'b0, upd_taken = 1'b0, lk_taken;
  logic [M-1:0]   lk_hist, upd_hist = '0;

  logic [PCW-1:0] lk_pc0 = '0, upd_pc0 = '0;
  logic           upd_valid0 = 1'b0, upd_taken0 = 1'b0, lk_taken0;
  logic [0:0]     lk_hist0, upd_hist0 = '0;

  gcorr_predictor #(.HIST_W(M), .CTR_W(N), .IDX_W(K), .PC_W(PCW)) u_gcorr_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist));

  gcorr_predictor #(.HIST_W(0), .CTR_W(N), .IDX_W(K), .PC_W(PCW)) u_gcorr_predictor_m0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc0), .lk_taken(lk_taken0), .lk_hist(lk_hist0),
    .upd_valid(upd_valid0), .upd_pc(upd_pc0), .upd_taken(upd_taken0), .upd_hist(upd_hist0));

  int total = 0, bad = 0;
  int ref_ctr [1 << (M + K)];
  int ref0 [1 << K];
  int ref_hist = 0;

  function automatic int ref_idx(input logic [PCW-1:0] pc, input int h);
    return (h << K) | int'(pc[K-1:0]);
  endfunction

  function automatic int sat(input int c, input logic up);
    if (up) return (c == CMAX) ? c : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(input logic [PCW-1:0] pc, input string req);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check(int'(lk_taken), (ref_ctr[ref_idx(pc, ref_hist)] >> (N - 1)) & 1, req);
    check(int'(lk_hist), ref_hist, {req, " hist"});
  endtask

  task automatic upd(input logic [PCW-1:0] pc, input logic t, input int h);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = M'(h);
    @(posedge clk);
    #1 upd_valid = 1'b0;
    ref_ctr[ref_idx(pc, h)] = sat(ref_ctr[ref_idx(pc, h)], t);
    ref_hist = ((ref_hist << 1) | int'(t)) & ((1 << M) - 1);
  endtask

  task automatic upd0(input logic [PCW-1:0] pc, input logic t, input logic h);
    @(negedge clk);
    upd_valid0 = 1'b1; upd_pc0 = pc; upd_taken0 = t; upd_hist0 = h;
    @(posedge clk);
    #1 upd_valid0 = 1'b0;
    ref0[pc[K-1:0]] = sat(ref0[pc[K-1:0]], t);
  endtask

  task automatic look0(input logic [PCW-1:0] pc, input string req);
    @(negedge clk);
    lk_pc0 = pc;
    #1;
    check(int'(lk_taken0), (ref0[pc[K-1:0]] >> (N - 1)) & 1, req);
    check(int'(lk_hist0), 0, {req, " hist"});
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd731));
    foreach (ref_ctr[i]) ref_ctr[i] = CINIT;
    foreach (ref0[i]) ref0[i] = CINIT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    look(32'h0000_0000, "R1");
    look(32'h0000_03FF, "R1");
    look(32'hDEAD_B155, "R1");

    // R11 / R5 / R7: update visible only after its edge
    @(negedge clk);
    lk_pc = 32'h40; upd_valid = 1'b1; upd_pc = 32'h40; upd_taken = 1'b1; upd_hist = 2'b00;
    #1 check(int'(lk_taken), 0, "R11 before edge");
    @(posedge clk);
    #1 upd_valid = 1'b0;
    ref_ctr[ref_idx(32'h40, 0)] = sat(ref_ctr[ref_idx(32'h40, 0)], 1'b1);
    ref_hist = 1;
    look(32'h40, "R11 after edge");            // history now 01, entry {01,0x40} untouched
    check(int'(lk_hist), 1, "R2 shift in taken");

    // R3/R4: train {00,0x80} with explicit history; other histories unchanged
    upd(32'h80, 1'b1, 0);
    upd(32'h80, 1'b1, 0);                       // {00,0x80}=3
    upd(32'h80, 1'b0, 3);                       // {11,0x80}=0, hist now ...
    upd(32'h999, 1'b0, 2);
    check(int'(lk_hist), ref_hist, "R2 hist after zeros");
    upd(32'h999, 1'b0, 1);                      // hist -> 00
    look(32'h80, "R3 selects trained table");   // hist 00 -> taken
    check(int'(lk_taken), 1, "R3 trained entry taken");
    upd(32'h5, 1'b1, 0);                        // hist -> 01
    look(32'h80, "R4 other table untouched");
    check(int'(lk_taken), 0, "R4 hist 01 still weak NT");

    // R9: upper PC bits alias
    upd(32'h5, 1'b1, 1);                        // hist -> 11, {01,0x5}
    upd(32'h7, 1'b0, 3);                        // hist -> 10
    upd(32'h7, 1'b1, 0);                        // hist -> 01
    look(32'hFFFF_F805, "R9 alias upper bits");
    check(int'(lk_taken), 1, "R9 aliased entry taken");

    // R5/R8/R6: saturation and hysteresis on {00,0x123}
    for (int i = 0; i < 5; i++) upd(32'h123, 1'b1, 0);
    check(ref_ctr[ref_idx(32'h123, 0)], CMAX, "R5 model at max");
    upd(32'h200, 1'b0, 2);
    upd(32'h200, 1'b0, 0);                      // hist -> 00
    look(32'h123, "R5 saturated high");
    upd(32'h123, 1'b0, 0);                      // 3 -> 2, hist 00
    look(32'h123, "R8 one miss keeps taken");
    check(int'(lk_taken), 1, "R8 still taken");
    upd(32'h123, 1'b0, 0);                      // 2 -> 1
    look(32'h123, "R8 second miss flips");
    check(int'(lk_taken), 0, "R8 flipped");
    for (int i = 0; i < 4; i++) upd(32'h123, 1'b0, 0);
    upd(32'h123, 1'b1, 0);                      // from 0 -> 1 : still NT
    look(32'h123, "R6 saturated low then one up");
    check(int'(lk_taken), 0, "R6 floor held");

    // R10: m=0 variant ignores history
    look0(32'h10, "R10 reset");
    upd0(32'h10, 1'b1, 1'b0);
    upd0(32'h10, 1'b1, 1'b1);                   // same counter -> 3
    upd0(32'h10, 1'b0, 1'b1);                   // -> 2
    look0(32'h10, "R10 history ignored");
    check(int'(lk_taken0), 1, "R10 pc-only counter");
    look0(32'h7FF_F410, "R10 alias R9");

    // constrained random with reference model
    for (int it = 0; it < 1500; it++) begin
      logic [PCW-1:0] rp;
      int h;
      rp = {$urandom} & 32'hFFFF_FC0F;
      look(rp, "R7 random lookup");
      h = ($urandom % 3 == 0) ? int'($urandom % (1 << M)) : ref_hist;
      rp = {$urandom} & 32'hFFFF_FC0F;
      upd(rp, ($urandom % 4) != 0, h);
    end
    look(32'h3, "R3 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule